// File: doc/BRIEF.md
# Superscalar Decode Stage Controller

This block sits between instruction fetch and rename in a superscalar pipeline. Each cycle it receives one fetch group of up to `LANES` instruction slots. Every slot carries a valid bit, its PC, its next-PC and pre-computed flags: control instruction, target resolved, mispredicted, predicted taken, and a source-register count. The block passes the leading run of valid slots on to rename, one cycle later. A slot with no source registers is tagged as ready to issue.

When rename, execute or commit asks for a stall, the block parks incoming groups in a FIFO of whole groups and holds fetch stalled. It drains that FIFO oldest-first before it accepts live groups again. A squash from commit, either a plain squash or a reorder-buffer squash, empties the FIFO and quiets the stage. The block also finds its own redirects. A slot whose resolved target is mispredicted, or a slot predicted taken that is not a control instruction, ends the group. It then flushes the FIFO and sends fetch a squash with that slot's next-PC.

The controller is a five-state machine: IDLE (0), RUN (1), BLOCK (2), DRAIN (3) and FLUSH (4).
- IDLE to RUN: the first non-empty group.
- IDLE, RUN or DRAIN to BLOCK: any stall input.
- BLOCK to DRAIN: all stalls clear while groups are parked.
- BLOCK to RUN: all stalls clear with nothing parked.
- DRAIN to RUN: the last parked group leaves.
- Any state to FLUSH: a commit squash or reorder-buffer squash.
- IDLE, RUN or DRAIN to FLUSH: a decode-detected redirect.
- FLUSH to RUN: both commit squash inputs are low.

Top module: `dec_stage_ctrl`

## Requirements
- R1: During and right after reset, `dec_state` is 0 (IDLE), every output slot is invalid, and `fe_stall`, `fe_squash`, `fe_mispred` and `skid_overflow` are 0. The state code is IDLE=0, RUN=1, BLOCK=2, DRAIN=3, FLUSH=4.
- R2: In IDLE or RUN with no stall or squash input, a group whose slot 0 is valid is forwarded on the next cycle, and the state becomes RUN. Output lane i carries input lane i's PC and next-PC for each lane up to, but not including, the first invalid lane. Every other lane reads invalid with zero PC fields.
- R3: `out_can_issue[i]` is 1 exactly when lane i is forwarded and its source count is zero.
- R4: A stall input in IDLE, RUN or DRAIN, with no commit squash, gives state BLOCK and `fe_stall`=1 on the next cycle, with no slots forwarded. The incoming group is parked if its slot 0 is valid.
- R5: In BLOCK, every incoming group with slot 0 valid is parked in arrival order, `fe_stall` stays 1, and nothing is forwarded.
- R6: In BLOCK, when all three stall inputs are low, the next state is DRAIN with `fe_stall`=1 if any group is parked. Otherwise it is RUN with `fe_stall`=0.
- R7: In DRAIN, one parked group per cycle, oldest first, is forwarded under the rules of R2 and removed. When the last one leaves, the state becomes RUN and `fe_stall` falls in the same cycle that group appears at the outputs.
- R8: A commit squash or reorder-buffer squash input gives state FLUSH on the next cycle from any state. It discards all parked groups and the incoming group, forwards nothing and drives `fe_stall`=0. FLUSH lasts until the cycle after both inputs are low, then the state is RUN.
- R9: A forwarded lane is bad if it is (control and target-resolved and mispredicted) or (predicted-taken and not control). Lanes up to and including the first bad lane are forwarded and later lanes are dropped. For one cycle `fe_squash` and `fe_mispred` are 1 and `fe_redirect_pc` holds the bad lane's next-PC. The state becomes FLUSH and all parked groups are discarded.
- R10: The FIFO holds `SKID_DEPTH` groups (default 4). A park attempt when it is full, with no removal in the same cycle, drops the group and sets `skid_overflow`, which stays 1 until reset.
- R11: In DRAIN with no stall or squash, an arriving group with slot 0 valid is parked behind the existing ones, so fetch that ignores `fe_stall` loses nothing and keeps its order.
- R12: In IDLE, RUN or FLUSH-free operation, a group with slot 0 invalid forwards nothing and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | LANES | Per-lane valid bit of the fetch group |
| in_pc | input | LANES*PC_W | Per-lane PC |
| in_npc | input | LANES*PC_W | Per-lane next-PC |
| in_ctrl | input | LANES | Lane is a control instruction |
| in_tgt_done | input | LANES | Lane's branch target already resolved |
| in_mispred | input | LANES | Lane's resolved target differs from prediction |
| in_pred_taken | input | LANES | Lane was predicted taken |
| in_nsrc | input | LANES*SRC_W | Per-lane source-register count |
| stall_rename | input | 1 | Stall request from rename |
| stall_exec | input | 1 | Stall request from execute |
| stall_commit | input | 1 | Stall request from commit |
| cmt_squash | input | 1 | Squash from commit |
| cmt_rob_squash | input | 1 | Reorder-buffer squash in progress |
| out_valid | output | LANES | Per-lane valid to rename |
| out_pc | output | LANES*PC_W | Per-lane PC to rename |
| out_npc | output | LANES*PC_W | Per-lane next-PC to rename |
| out_can_issue | output | LANES | Lane has no sources and may issue at once |
| fe_stall | output | 1 | Hold fetch |
| fe_squash | output | 1 | Decode-detected squash to fetch |
| fe_mispred | output | 1 | Squash cause is a misprediction |
| fe_redirect_pc | output | PC_W | Fetch restart address |
| skid_overflow | output | 1 | Sticky FIFO overflow flag |
| dec_state | output | 3 | Current controller state code |

## Verification
Every output is registered. A stimulus sampled at one rising edge is therefore visible right after that edge: forwarded lanes, state, `fe_stall`, the redirect triple and the overflow flag all change one cycle after the inputs that cause them. The bench drives inputs on the falling edge and advances its queue-based model on the rising edge. It compares all outputs at the following falling edge, so each check lands exactly one cycle after its cause. Multi-cycle effects, such as the drain order and the FLUSH exit, are checked the same way cycle by cycle against the model's queue of parked groups.

// File: rtl/dec_stage_pkg.sv
`timescale 1ns/1ps
package dec_stage_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLOCK = 3'd2,
        ST_DRAIN = 3'd3,
        ST_FLUSH = 3'd4
    } dec_state_e;

    // bit positions of the per-lane flags inside a packed lane record;
    // the source count, PC and next-PC follow above these
    localparam int OFF_VALID = 0;
    localparam int OFF_CTRL  = 1;
    localparam int OFF_TGT   = 2;
    localparam int OFF_MISP  = 3;
    localparam int OFF_PTK   = 4;
    localparam int OFF_NSRC  = 5;

endpackage

// File: rtl/dec_skid_fifo.sv
`timescale 1ns/1ps
module dec_skid_fifo #(
    parameter int GW    = 8,
    parameter int DEPTH = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic                            pop,
    input  logic                            flush,
    input  logic [GW-1:0]                   wdata,
    output logic [GW-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]      count,
    output logic                            overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [GW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          full;
    logic          empty;
    logic          do_push;
    logic          do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop & ~empty & ~flush;
    assign do_push = push & ~flush & (~full | do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full && !do_pop) overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/dec_lane_pick.sv
`timescale 1ns/1ps
module dec_lane_pick
    import dec_stage_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PC_W  = 32,
    parameter int SRC_W = 2
) (
    input  logic [LANES*(OFF_NSRC+SRC_W+2*PC_W)-1:0] grp,
    output logic [LANES-1:0]                         fwd,
    output logic [LANES-1:0]                         can_issue,
    output logic [LANES*PC_W-1:0]                    pc_o,
    output logic [LANES*PC_W-1:0]                    npc_o,
    output logic                                     redirect,
    output logic [PC_W-1:0]                          redirect_pc
);
    localparam int OFF_PC  = OFF_NSRC + SRC_W;
    localparam int OFF_NPC = OFF_PC + PC_W;
    localparam int SW      = OFF_NPC + PC_W;

    logic [LANES-1:0]  lane_v;
    logic [LANES-1:0]  lane_bad;
    logic [LANES-1:0]  lane_nosrc;
    logic [PC_W-1:0]   lane_pc  [LANES];
    logic [PC_W-1:0]   lane_npc [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SW-1:0] rec;
        assign rec           = grp[i*SW +: SW];
        assign lane_v[i]     = rec[OFF_VALID];
        assign lane_bad[i]   = (rec[OFF_CTRL] & rec[OFF_TGT] & rec[OFF_MISP])
                             | (rec[OFF_PTK] & ~rec[OFF_CTRL]);
        assign lane_nosrc[i] = (rec[OFF_NSRC +: SRC_W] == '0);
        assign lane_pc[i]    = rec[OFF_PC +: PC_W];
        assign lane_npc[i]   = rec[OFF_NPC +: PC_W];
        assign can_issue[i]  = fwd[i] & lane_nosrc[i];
        assign pc_o[i*PC_W +: PC_W]  = fwd[i] ? lane_pc[i]  : '0;
        assign npc_o[i*PC_W +: PC_W] = fwd[i] ? lane_npc[i] : '0;
    end

    // forwarding walks lanes in order, stopping at an empty lane or
    // just after the first bad one
    always_comb begin
        logic alive;
        alive       = 1'b1;
        fwd         = '0;
        redirect    = 1'b0;
        redirect_pc = '0;
        for (int i = 0; i < LANES; i++) begin
            if (alive && lane_v[i]) begin
                fwd[i] = 1'b1;
                if (lane_bad[i]) begin
                    redirect    = 1'b1;
                    redirect_pc = lane_npc[i];
                    alive       = 1'b0;
                end
            end else begin
                alive = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dec_stage_ctrl.sv
`timescale 1ns/1ps
module dec_stage_ctrl
    import dec_stage_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int PC_W       = 32,
    parameter int SRC_W      = 2,
    parameter int SKID_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         in_valid,
    input  logic [LANES*PC_W-1:0]    in_pc,
    input  logic [LANES*PC_W-1:0]    in_npc,
    input  logic [LANES-1:0]         in_ctrl,
    input  logic [LANES-1:0]         in_tgt_done,
    input  logic [LANES-1:0]         in_mispred,
    input  logic [LANES-1:0]         in_pred_taken,
    input  logic [LANES*SRC_W-1:0]   in_nsrc,
    input  logic                     stall_rename,
    input  logic                     stall_exec,
    input  logic                     stall_commit,
    input  logic                     cmt_squash,
    input  logic                     cmt_rob_squash,
    output logic [LANES-1:0]         out_valid,
    output logic [LANES*PC_W-1:0]    out_pc,
    output logic [LANES*PC_W-1:0]    out_npc,
    output logic [LANES-1:0]         out_can_issue,
    output logic                     fe_stall,
    output logic                     fe_squash,
    output logic                     fe_mispred,
    output logic [PC_W-1:0]          fe_redirect_pc,
    output logic                     skid_overflow,
    output logic [2:0]               dec_state
);
    localparam int OFF_PC  = OFF_NSRC + SRC_W;
    localparam int OFF_NPC = OFF_PC + PC_W;
    localparam int SW      = OFF_NPC + PC_W;
    localparam int GW      = LANES * SW;
    localparam int CNT_W   = $clog2(SKID_DEPTH + 1);

    dec_state_e        state_q;
    dec_state_e        state_d;

    logic [GW-1:0]     grp_in;
    logic [GW-1:0]     grp_head;
    logic [GW-1:0]     grp_sel;
    logic [CNT_W-1:0]  sk_count;

    logic              stall_any;
    logic              squash_in;
    logic              use_skid;
    logic              do_fwd;
    logic              sk_push;
    logic              sk_pop;
    logic              sk_flush;

    logic [LANES-1:0]      pk_fwd;
    logic [LANES-1:0]      pk_can;
    logic [LANES*PC_W-1:0] pk_pc;
    logic [LANES*PC_W-1:0] pk_npc;
    logic                  pk_redirect;
    logic [PC_W-1:0]       pk_rpc;

    // pack the live fetch group into lane records
    for (genvar i = 0; i < LANES; i++) begin : g_pack
        assign grp_in[i*SW + OFF_VALID]          = in_valid[i];
        assign grp_in[i*SW + OFF_CTRL]           = in_ctrl[i];
        assign grp_in[i*SW + OFF_TGT]            = in_tgt_done[i];
        assign grp_in[i*SW + OFF_MISP]           = in_mispred[i];
        assign grp_in[i*SW + OFF_PTK]            = in_pred_taken[i];
        assign grp_in[i*SW + OFF_NSRC +: SRC_W]  = in_nsrc[i*SRC_W +: SRC_W];
        assign grp_in[i*SW + OFF_PC   +: PC_W]   = in_pc[i*PC_W +: PC_W];
        assign grp_in[i*SW + OFF_NPC  +: PC_W]   = in_npc[i*PC_W +: PC_W];
    end

    dec_skid_fifo #(
        .GW    (GW),
        .DEPTH (SKID_DEPTH)
    ) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (sk_push),
        .pop      (sk_pop),
        .flush    (sk_flush),
        .wdata    (grp_in),
        .head     (grp_head),
        .count    (sk_count),
        .overflow (skid_overflow)
    );

    assign grp_sel = use_skid ? grp_head : grp_in;

    dec_lane_pick #(
        .LANES (LANES),
        .PC_W  (PC_W),
        .SRC_W (SRC_W)
    ) u_pick (
        .grp         (grp_sel),
        .fwd         (pk_fwd),
        .can_issue   (pk_can),
        .pc_o        (pk_pc),
        .npc_o       (pk_npc),
        .redirect    (pk_redirect),
        .redirect_pc (pk_rpc)
    );

    assign stall_any = stall_rename | stall_exec | stall_commit;
    assign squash_in = cmt_squash | cmt_rob_squash;
    assign use_skid  = (state_q == ST_DRAIN);

    // next-state and FIFO control
    always_comb begin
        state_d  = state_q;
        do_fwd   = 1'b0;
        sk_push  = 1'b0;
        sk_pop   = 1'b0;
        sk_flush = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RUN, ST_DRAIN: begin
                if (squash_in) begin
                    state_d  = ST_FLUSH;
                    sk_flush = 1'b1;
                end else if (stall_any) begin
                    state_d = ST_BLOCK;
                    sk_push = in_valid[0];
                end else if (state_q == ST_DRAIN) begin
                    do_fwd  = 1'b1;
                    sk_pop  = 1'b1;
                    sk_push = in_valid[0];
                    if (pk_redirect) begin
                        state_d  = ST_FLUSH;
                        sk_flush = 1'b1;
                    end else if (sk_count == CNT_W'(1) && !in_valid[0]) begin
                        state_d = ST_RUN;
                    end else begin
                        state_d = ST_DRAIN;
                    end
                end else if (in_valid[0]) begin
                    do_fwd = 1'b1;
                    if (pk_redirect) begin
                        state_d  = ST_FLUSH;
                        sk_flush = 1'b1;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_BLOCK: begin
                sk_push = in_valid[0];
                if (squash_in) begin
                    state_d  = ST_FLUSH;
                    sk_flush = 1'b1;
                end else if (!stall_any) begin
                    state_d = (sk_count == '0 && !in_valid[0]) ? ST_RUN : ST_DRAIN;
                end
            end
            ST_FLUSH: begin
                sk_flush = squash_in;
                if (!squash_in) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid      <= '0;
            out_pc         <= '0;
            out_npc        <= '0;
            out_can_issue  <= '0;
            fe_stall       <= 1'b0;
            fe_squash      <= 1'b0;
            fe_mispred     <= 1'b0;
            fe_redirect_pc <= '0;
        end else begin
            out_valid      <= do_fwd ? pk_fwd : '0;
            out_pc         <= do_fwd ? pk_pc  : '0;
            out_npc        <= do_fwd ? pk_npc : '0;
            out_can_issue  <= do_fwd ? pk_can : '0;
            fe_stall       <= (state_d == ST_BLOCK) || (state_d == ST_DRAIN);
            fe_squash      <= do_fwd & pk_redirect;
            fe_mispred     <= do_fwd & pk_redirect;
            fe_redirect_pc <= (do_fwd && pk_redirect) ? pk_rpc : '0;
        end
    end

    assign dec_state = state_q;

endmodule

// File: rtl/dec_stage_chk.sv
`timescale 1ns/1ps
module dec_stage_chk
    import dec_stage_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall_rename,
    input logic             stall_exec,
    input logic             stall_commit,
    input logic             cmt_squash,
    input logic             cmt_rob_squash,
    input logic [LANES-1:0] out_valid,
    input logic             fe_stall,
    input logic             fe_squash,
    input logic             fe_mispred,
    input logic             skid_overflow,
    input logic [2:0]       dec_state
);
    logic any_stall;
    logic any_sq;
    assign any_stall = stall_rename | stall_exec | stall_commit;
    assign any_sq    = cmt_squash | cmt_rob_squash;

    // R2: forwarded lanes always form a run starting at lane 0
    p_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & (out_valid + 1'b1)) == '0));

    // R4: a stall in an active state leads to BLOCK
    p_block_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_state == ST_IDLE || dec_state == ST_RUN || dec_state == ST_DRAIN)
         && any_stall && !any_sq) |=> (dec_state == ST_BLOCK));

    // R5: BLOCK forwards nothing and holds fetch
    p_block_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_state == ST_BLOCK) |-> (out_valid == '0 && fe_stall));

    // R8: commit squash always leads to FLUSH
    p_commit_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_sq |=> (dec_state == ST_FLUSH));

    // R8: FLUSH exits to RUN once both squash inputs are low
    p_flush_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_state == ST_FLUSH && !any_sq) |=> (dec_state == ST_RUN));

    // R8: fetch is not held during FLUSH
    p_flush_nostall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_state == ST_FLUSH) |-> !fe_stall);

    // R9: decode squash comes with mispredict and the FLUSH state
    p_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fe_squash |-> (fe_mispred && dec_state == ST_FLUSH));

    // R10: overflow flag is sticky
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skid_overflow |=> skid_overflow);

endmodule

bind dec_stage_ctrl dec_stage_chk #(.LANES(LANES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall_rename   (stall_rename),
    .stall_exec     (stall_exec),
    .stall_commit   (stall_commit),
    .cmt_squash     (cmt_squash),
    .cmt_rob_squash (cmt_rob_squash),
    .out_valid      (out_valid),
    .fe_stall       (fe_stall),
    .fe_squash      (fe_squash),
    .fe_mispred     (fe_mispred),
    .skid_overflow  (skid_overflow),
    .dec_state      (dec_state)
);

// File: tb/sim_dec_stage_ctrl.sv
`timescale 1ns/1ps
module sim_dec_stage_ctrl;
    localparam int L  = 4;
    localparam int PW = 32;
    localparam int SB = 2;
    localparam int D  = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic [L-1:0]    in_valid = '0, in_ctrl = '0, in_tgt = '0, in_misp = '0, in_ptk = '0;
    logic [L*PW-1:0] in_pc = '0, in_npc = '0;
    logic [L*SB-1:0] in_nsrc = '0;
    logic            st_r = 0, st_e = 0, st_c = 0, c_sq = 0, c_rob = 0;

    logic [L-1:0]    out_valid, out_ci;
    logic [L*PW-1:0] out_pc, out_npc;
    logic            fe_stall, fe_squash, fe_mispred, ovf;
    logic [PW-1:0]   fe_rpc;
    logic [2:0]      dec_state;

    dec_stage_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_npc(in_npc),
        .in_ctrl(in_ctrl), .in_tgt_done(in_tgt), .in_mispred(in_misp),
        .in_pred_taken(in_ptk), .in_nsrc(in_nsrc), .stall_rename(st_r),
        .stall_exec(st_e), .stall_commit(st_c), .cmt_squash(c_sq),
        .cmt_rob_squash(c_rob), .out_valid(out_valid), .out_pc(out_pc),
        .out_npc(out_npc), .out_can_issue(out_ci), .fe_stall(fe_stall),
        .fe_squash(fe_squash), .fe_mispred(fe_mispred), .fe_redirect_pc(fe_rpc),
        .skid_overflow(ovf), .dec_state(dec_state)
    );

    typedef struct {
        bit          v  [L];
        bit [PW-1:0] pc [L];
        bit [PW-1:0] npc[L];
        bit          ct [L];
        bit          td [L];
        bit          mp [L];
        bit          pt [L];
        bit [SB-1:0] ns [L];
    } grp_t;

    grp_t  skq[$];
    int    ms = 0;
    bit    m_ovf = 0;
    bit [L-1:0]  e_valid, e_ci;
    bit [PW-1:0] e_pc [L];
    bit [PW-1:0] e_npc[L];
    bit          e_stall, e_sq;
    bit [PW-1:0] e_rpc;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (phase %s) %s act=%0h exp=%0h", req, cur_req, what, act, exp);
        end
    endtask

    function automatic grp_t cur_grp();
        grp_t g;
        for (int i = 0; i < L; i++) begin
            g.v[i]   = in_valid[i];
            g.pc[i]  = in_pc[i*PW +: PW];
            g.npc[i] = in_npc[i*PW +: PW];
            g.ct[i]  = in_ctrl[i];
            g.td[i]  = in_tgt[i];
            g.mp[i]  = in_misp[i];
            g.pt[i]  = in_ptk[i];
            g.ns[i]  = in_nsrc[i*SB +: SB];
        end
        return g;
    endfunction

    task automatic mpush(input grp_t g);
        if (skq.size() == D) m_ovf = 1;
        else skq.push_back(g);
    endtask

    task automatic mfwd(input grp_t g, output bit hit);
        bit alive = 1;
        hit = 0;
        for (int i = 0; i < L; i++) begin
            if (alive && g.v[i]) begin
                e_valid[i] = 1;
                e_pc[i]    = g.pc[i];
                e_npc[i]   = g.npc[i];
                e_ci[i]    = (g.ns[i] == 0);
                if ((g.ct[i] && g.td[i] && g.mp[i]) || (g.pt[i] && !g.ct[i])) begin
                    hit   = 1;
                    e_rpc = g.npc[i];
                    alive = 0;
                end
            end else alive = 0;
        end
        e_sq = hit;
    endtask

    task automatic clear_exp();
        e_valid = '0; e_ci = '0; e_stall = 0; e_sq = 0; e_rpc = '0;
        for (int i = 0; i < L; i++) begin e_pc[i] = '0; e_npc[i] = '0; end
    endtask

    task automatic model_step();
        grp_t ig;
        bit   sqin, stl, hit;
        ig   = cur_grp();
        sqin = c_sq | c_rob;
        stl  = st_r | st_e | st_c;
        hit  = 0;
        clear_exp();
        case (ms)
            0, 1, 3: begin
                if (sqin) begin
                    ms = 4; skq.delete();
                end else if (stl) begin
                    ms = 2; if (ig.v[0]) mpush(ig);
                end else if (ms == 3) begin
                    grp_t g;
                    g = skq.pop_front();
                    if (ig.v[0]) mpush(ig);
                    mfwd(g, hit);
                    if (hit) begin ms = 4; skq.delete(); end
                    else ms = (skq.size() == 0) ? 1 : 3;
                end else if (ig.v[0]) begin
                    mfwd(ig, hit);
                    ms = hit ? 4 : 1;
                    if (hit) skq.delete();
                end
            end
            2: begin
                if (sqin) begin
                    ms = 4; skq.delete();
                end else begin
                    if (ig.v[0]) mpush(ig);
                    if (!stl) ms = (skq.size() == 0) ? 1 : 3;
                end
            end
            default: if (!sqin) ms = 1;
        endcase
        e_stall = (ms == 2 || ms == 3);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; m_ovf = 0; skq.delete(); clear_exp();
        end else model_step();
    end

    task automatic compare();
        if (!rst_n) return;
        chk(dec_state == 3'(ms), cur_req, "state", dec_state, ms);
        chk(out_valid == e_valid, "R2", "out_valid", out_valid, e_valid);
        for (int i = 0; i < L; i++) begin
            chk(out_pc[i*PW +: PW] == e_pc[i], "R2", $sformatf("pc%0d", i), out_pc[i*PW +: PW], e_pc[i]);
            chk(out_npc[i*PW +: PW] == e_npc[i], "R2", $sformatf("npc%0d", i), out_npc[i*PW +: PW], e_npc[i]);
        end
        chk(out_ci == e_ci, "R3", "can_issue", out_ci, e_ci);
        chk(fe_stall == e_stall, "R6", "fe_stall", fe_stall, e_stall);
        chk(fe_squash == e_sq && fe_mispred == e_sq, "R9", "squash/mispred",
            {fe_squash, fe_mispred}, {e_sq, e_sq});
        chk(fe_rpc == e_rpc, "R9", "redirect_pc", fe_rpc, e_rpc);
        chk(ovf == m_ovf, "R10", "overflow", ovf, m_ovf);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic set_ctl(input bit r, input bit e, input bit c, input bit sq, input bit rob);
        st_r = r; st_e = e; st_c = c; c_sq = sq; c_rob = rob;
    endtask

    task automatic set_grp(input int n, input bit hole, input bit bad);
        for (int i = 0; i < L; i++) begin
            in_valid[i] = (i < n);
            if (hole && i > 0) in_valid[i] = 1'($urandom % 2);
            in_pc[i*PW +: PW]  = $urandom;
            in_npc[i*PW +: PW] = $urandom;
            in_ctrl[i] = 1'($urandom % 2);
            in_tgt[i]  = 1'($urandom % 2);
            in_misp[i] = bad ? ($urandom % 5 == 0) : 1'b0;
            in_ptk[i]  = bad ? ($urandom % 7 == 0) : 1'b0;
            in_nsrc[i*SB +: SB] = SB'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        set_ctl(0, 0, 0, 0, 0);
        set_grp(0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(dec_state == 3'd0, "R1", "reset state", dec_state, 0);
        chk(out_valid == '0 && fe_stall == 0 && fe_squash == 0 && fe_mispred == 0,
            "R1", "reset outputs", {out_valid, fe_stall, fe_squash, fe_mispred}, 0);
        chk(ovf == 0, "R1", "reset overflow", ovf, 0);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cur_req = "R1";
        do_reset();

        cur_req = "R12";
        repeat (3) begin set_grp(0, 0, 0); tick(); end

        cur_req = "R2";
        repeat (20) begin set_grp($urandom % 5, $urandom % 2, 0); tick(); end
        cur_req = "R12";
        set_grp(0, 0, 0); tick();

        cur_req = "R4";
        set_ctl(0, 1, 0, 0, 0); set_grp(4, 0, 0); tick();
        cur_req = "R5";
        repeat (2) begin set_grp(3, 0, 0); tick(); end
        cur_req = "R6";
        set_ctl(0, 0, 0, 0, 0); set_grp(0, 0, 0); tick();
        cur_req = "R7";
        repeat (5) begin set_grp(0, 0, 0); tick(); end

        cur_req = "R10";
        set_ctl(0, 0, 1, 0, 0);
        repeat (7) begin set_grp(4, 0, 0); tick(); end
        set_ctl(0, 0, 0, 0, 0);
        repeat (8) begin set_grp(0, 0, 0); tick(); end
        cur_req = "R1";
        do_reset();

        cur_req = "R8";
        repeat (3) begin set_grp(4, 0, 0); tick(); end
        set_ctl(1, 0, 0, 0, 0);
        repeat (2) begin set_grp(4, 0, 0); tick(); end
        set_ctl(1, 0, 0, 1, 0); set_grp(4, 0, 0); tick();
        set_ctl(0, 0, 0, 1, 0); tick();
        set_ctl(0, 0, 0, 0, 1); tick();
        set_ctl(0, 0, 0, 0, 0);
        repeat (3) begin set_grp(2, 0, 0); tick(); end

        cur_req = "R9";
        set_grp(4, 0, 0);
        in_ctrl[1] = 1; in_tgt[1] = 1; in_misp[1] = 1;
        tick();
        set_grp(4, 0, 0); tick();
        set_grp(4, 0, 0);
        in_ctrl[2] = 0; in_ptk[2] = 1;
        tick();
        set_grp(0, 0, 0); tick();
        set_ctl(0, 1, 0, 0, 0);
        repeat (3) begin set_grp(4, 0, 0); tick(); end
        set_ctl(0, 0, 0, 0, 0);
        set_grp(0, 0, 0);
        tick();
        tick();
        repeat (20) begin set_grp($urandom % 5, 0, 1); tick(); end

        cur_req = "R11";
        set_ctl(1, 0, 0, 0, 0);
        repeat (2) begin set_grp(4, 0, 0); tick(); end
        set_ctl(0, 0, 0, 0, 0);
        repeat (4) begin set_grp(3, 0, 0); tick(); end
        repeat (3000) begin
            set_ctl($urandom % 6 == 0, $urandom % 8 == 0, $urandom % 9 == 0,
                    $urandom % 30 == 0, $urandom % 40 == 0);
            if (fe_stall && ($urandom % 2)) set_grp(0, 0, 0);
            else set_grp($urandom % 5, $urandom % 4 == 0, 1);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule